// File: doc/BRIEF.md
# Shared Block Access Guard

This block sits in front of one shared non-volatile array that two requesters use. One requester is a fixed contactless-side state machine, the other is a contact-side processor. The array is split into sectors of equal-sized blocks, and both sides see the same layout. A requester can only move one whole block at a time. It cannot reach single bytes.

A rights table holds four bits for every block. Each side has its own read bit and its own write bit. Software loads the table through a configuration port, and reset clears the table to "nothing allowed". For each request the guard picks one requester and checks the rights once. It then streams the block one byte per cycle, or it refuses the request and raises a violation pulse tagged with the requester.

The array is modelled as a plain synchronous memory. Parameters must be powers of two. The defaults are 16 sectors of 4 blocks, with 16 bytes per block.

Top module: `shared_block_guard`

## Requirements
- R1: After reset every rights entry is zero, so every request is refused. While no request is active, `cl_take`, `ct_take`, `rd_valid`, `rd_data`, `done` and `viol` are all low.
- R2: The block number is sector*4+block. Byte k of a block is stored at block*16+k. Data written by either side is read back unchanged by either side.
- R3: Rights entry bits are: bit 0 contactless read, bit 1 contactless write, bit 2 contact read, bit 3 contact write. A request is granted exactly when the bit for its side and direction is set.
- R4: A refused request leaves memory unchanged. In the cycle after the request is sampled, `viol` is high for exactly one cycle, `viol_side` shows the requester (0 contactless, 1 contact), `rd_valid` is low and `rd_data` is zero. `rd_data` is zero whenever `rd_valid` is low.
- R5: If both sides request in the same idle cycle, the contactless side is served. A contact request held high is taken 17 cycles after the contactless take.
- R6: A granted transfer moves 16 bytes. Counting the take cycle as cycle 0, write byte k is sampled from the owner's write-data port in cycle k. Read byte k appears with `rd_valid` in cycle k+1. `done` pulses for one cycle in cycle 16.
- R7: Rights are checked only when the request is taken. Revoking them during a transfer does not cut it short. Later requests see the new rights.
- R8: Exactly one of `cl_take`/`ct_take` pulses for one cycle per accepted request, whether granted or refused. No request is taken while a transfer is in progress.
- R9: When `cfg_we` is high, `cfg_rights` is written into entry `cfg_idx` (= sector*4+block) at the clock edge. The new rights apply to requests sampled from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_req | input | 1 | Contactless request |
| cl_wr | input | 1 | Contactless direction, 1 = write |
| cl_sector | input | 4 | Contactless sector number |
| cl_block | input | 2 | Contactless block within sector |
| cl_wdata | input | 8 | Contactless write byte |
| ct_req | input | 1 | Contact request |
| ct_wr | input | 1 | Contact direction, 1 = write |
| ct_sector | input | 4 | Contact sector number |
| ct_block | input | 2 | Contact block within sector |
| ct_wdata | input | 8 | Contact write byte |
| cfg_we | input | 1 | Rights table write enable |
| cfg_idx | input | 6 | Rights entry index |
| cfg_rights | input | 4 | Rights value to store |
| cl_take | output | 1 | Contactless request accepted (one cycle) |
| ct_take | output | 1 | Contact request accepted (one cycle) |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer finished (one cycle) |
| viol | output | 1 | Access refused (one cycle) |
| viol_side | output | 1 | Side of refused access, 0 contactless, 1 contact |

## Verification
The assertions check several rules on every cycle:
- the two take pulses never coincide and never come back to back;
- `viol` and `done` last one cycle;
- a violation comes with a take and no read data;
- `rd_data` is zero whenever it is not valid;
- a contact take never follows a cycle in which the contactless side was requesting.

The bench scenarios are the only way to show the parts that depend on stored state: the address layout across every block, the grant decision for all sixteen rights values, that memory is unchanged after a refused write, the exact byte timing, and that revoking rights mid-transfer has no effect on it.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DENY = 2'd2
  } xfer_state_t;

  localparam logic SIDE_CL = 1'b0;
  localparam logic SIDE_CT = 1'b1;

  // rights nibble: {ct_write, ct_read, cl_write, cl_read}
  localparam int RIGHTS_W = 4;
endpackage

// File: rtl/sbg_rights.sv
module sbg_rights
  import sbg_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [RIGHTS_W-1:0] cfg_val,
  input  logic [IDX_W-1:0]    look_idx,
  input  logic                look_side,
  input  logic                look_wr,
  output logic                look_ok
);
  localparam int ENTRIES = 2 ** IDX_W;

  logic [ENTRIES-1:0][RIGHTS_W-1:0] tab_q;
  logic [RIGHTS_W-1:0]              entry;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q <= '0;
    end else if (cfg_we) begin
      tab_q[cfg_idx] <= cfg_val;
    end
  end

  always_comb begin
    entry   = tab_q[look_idx];
    look_ok = entry[{look_side, look_wr}];
  end
endmodule

// File: rtl/sbg_arbiter.sv
module sbg_arbiter
  import sbg_pkg::*;
#(
  parameter int SEC_W = 4,
  parameter int BLK_W = 2
) (
  input  logic                   cl_req,
  input  logic                   cl_wr,
  input  logic [SEC_W-1:0]       cl_sector,
  input  logic [BLK_W-1:0]       cl_block,
  input  logic                   ct_req,
  input  logic                   ct_wr,
  input  logic [SEC_W-1:0]       ct_sector,
  input  logic [BLK_W-1:0]       ct_block,
  output logic                   pick_valid,
  output logic                   pick_side,
  output logic                   pick_wr,
  output logic [SEC_W+BLK_W-1:0] pick_idx
);
  // fixed priority: contactless side wins a tie
  always_comb begin
    pick_valid = cl_req | ct_req;
    if (cl_req) begin
      pick_side = SIDE_CL;
      pick_wr   = cl_wr;
      pick_idx  = {cl_sector, cl_block};
    end else begin
      pick_side = SIDE_CT;
      pick_wr   = ct_wr;
      pick_idx  = {ct_sector, ct_block};
    end
  end
endmodule

// File: rtl/sbg_xfer.sv
module sbg_xfer
  import sbg_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int BEAT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    pick_valid,
  input  logic                    pick_side,
  input  logic                    pick_wr,
  input  logic [IDX_W-1:0]        pick_idx,
  input  logic                    pick_ok,
  output logic                    cl_take,
  output logic                    ct_take,
  output logic                    viol,
  output logic                    viol_side,
  output logic                    done,
  output logic                    rd_valid,
  output logic                    owner,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [IDX_W+BEAT_W-1:0] mem_addr
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

  xfer_state_t       state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              owner_q, wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ctx_load;
  logic              take_cl_q, take_cl_d, take_ct_q, take_ct_d;
  logic              viol_q, viol_d, vside_q, vside_d;
  logic              done_q, done_d, rdv_q, rdv_d;

  assign ctx_load = (state_q == ST_IDLE) && pick_valid;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    take_cl_d = 1'b0;
    take_ct_d = 1'b0;
    viol_d    = 1'b0;
    vside_d   = vside_q;
    done_d    = 1'b0;
    rdv_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_valid) begin
          take_cl_d = (pick_side == SIDE_CL);
          take_ct_d = (pick_side == SIDE_CT);
          beat_d    = '0;
          if (pick_ok) begin
            state_d = ST_MOVE;
          end else begin
            state_d = ST_DENY;
            viol_d  = 1'b1;
            vside_d = pick_side;
          end
        end
      end
      ST_MOVE: begin
        rdv_d  = !wr_q;
        beat_d = beat_q + BEAT_W'(1);
        if (beat_q == LAST_BEAT) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_DENY: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      take_cl_q <= 1'b0;
      take_ct_q <= 1'b0;
      viol_q    <= 1'b0;
      vside_q   <= 1'b0;
      done_q    <= 1'b0;
      rdv_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      beat_q    <= beat_d;
      take_cl_q <= take_cl_d;
      take_ct_q <= take_ct_d;
      viol_q    <= viol_d;
      vside_q   <= vside_d;
      done_q    <= done_d;
      rdv_q     <= rdv_d;
    end
  end

  // request context, loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
    end else if (ctx_load) begin
      owner_q <= pick_side;
      wr_q    <= pick_wr;
      idx_q   <= pick_idx;
    end
  end

  assign cl_take   = take_cl_q;
  assign ct_take   = take_ct_q;
  assign viol      = viol_q;
  assign viol_side = vside_q;
  assign done      = done_q;
  assign rd_valid  = rdv_q;
  assign owner     = owner_q;
  assign mem_en    = (state_q == ST_MOVE);
  assign mem_we    = mem_en && wr_q;
  assign mem_addr  = {idx_q, beat_q};
endmodule

// File: rtl/sbg_mem.sv
module sbg_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      arr[addr] <= wdata;
    end
  end

  // read register returns zero outside a read beat
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (en && !we) begin
      rd_q <= arr[addr];
    end else begin
      rd_q <= '0;
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/shared_block_guard.sv
module shared_block_guard
  import sbg_pkg::*;
#(
  parameter int SECTORS     = 16,
  parameter int BLOCKS      = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int DATA_W      = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cl_req,
  input  logic                                       cl_wr,
  input  logic [$clog2(SECTORS)-1:0]                 cl_sector,
  input  logic [$clog2(BLOCKS)-1:0]                  cl_block,
  input  logic [DATA_W-1:0]                          cl_wdata,
  input  logic                                       ct_req,
  input  logic                                       ct_wr,
  input  logic [$clog2(SECTORS)-1:0]                 ct_sector,
  input  logic [$clog2(BLOCKS)-1:0]                  ct_block,
  input  logic [DATA_W-1:0]                          ct_wdata,
  input  logic                                       cfg_we,
  input  logic [$clog2(SECTORS)+$clog2(BLOCKS)-1:0]  cfg_idx,
  input  logic [3:0]                                 cfg_rights,
  output logic                                       cl_take,
  output logic                                       ct_take,
  output logic                                       rd_valid,
  output logic [DATA_W-1:0]                          rd_data,
  output logic                                       done,
  output logic                                       viol,
  output logic                                       viol_side
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int BLK_W  = $clog2(BLOCKS);
  localparam int IDX_W  = SEC_W + BLK_W;
  localparam int BEAT_W = $clog2(BLOCK_BYTES);
  localparam int ADDR_W = IDX_W + BEAT_W;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_ni = rsync_q[1];

  logic              pick_valid, pick_side, pick_wr, pick_ok;
  logic [IDX_W-1:0]  pick_idx;
  logic              owner, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] wdata;

  sbg_arbiter #(.SEC_W(SEC_W), .BLK_W(BLK_W)) u_arb (
    .cl_req    (cl_req),
    .cl_wr     (cl_wr),
    .cl_sector (cl_sector),
    .cl_block  (cl_block),
    .ct_req    (ct_req),
    .ct_wr     (ct_wr),
    .ct_sector (ct_sector),
    .ct_block  (ct_block),
    .pick_valid(pick_valid),
    .pick_side (pick_side),
    .pick_wr   (pick_wr),
    .pick_idx  (pick_idx)
  );

  sbg_rights #(.IDX_W(IDX_W)) u_rights (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_val  (cfg_rights),
    .look_idx (pick_idx),
    .look_side(pick_side),
    .look_wr  (pick_wr),
    .look_ok  (pick_ok)
  );

  sbg_xfer #(.IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_xfer (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .pick_valid(pick_valid),
    .pick_side (pick_side),
    .pick_wr   (pick_wr),
    .pick_idx  (pick_idx),
    .pick_ok   (pick_ok),
    .cl_take   (cl_take),
    .ct_take   (ct_take),
    .viol      (viol),
    .viol_side (viol_side),
    .done      (done),
    .rd_valid  (rd_valid),
    .owner     (owner),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
  );

  assign wdata = (owner == SIDE_CT) ? ct_wdata : cl_wdata;

  sbg_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_ni(rst_ni),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (wdata),
    .rdata (rd_data)
  );
endmodule

// File: rtl/sbg_chk.sv
module sbg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cl_req,
  input logic              cl_take,
  input logic              ct_take,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              done,
  input logic              viol
);
  assert_take_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cl_take && ct_take));

  assert_take_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_take || ct_take) |=> !(cl_take || ct_take));

  assert_viol_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);

  assert_viol_with_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> ((cl_take || ct_take) && !rd_valid));

  assert_rd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  assert_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ct_take |-> !$past(cl_req));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind shared_block_guard sbg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cl_req  (cl_req),
  .cl_take (cl_take),
  .ct_take (ct_take),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .done    (done),
  .viol    (viol)
);

// File: tb/shared_block_guard_tb.sv
`timescale 1ns/1ps
module shared_block_guard_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cl_req, cl_wr, ct_req, ct_wr, cfg_we;
  logic [3:0] cl_sector, ct_sector, cfg_rights;
  logic [1:0] cl_block, ct_block;
  logic [7:0] cl_wdata, ct_wdata;
  logic [5:0] cfg_idx;
  logic cl_take, ct_take, rd_valid, done, viol, viol_side;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [7:0] model [0:1023];

  always #2 clk = ~clk;

  shared_block_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .cl_req(cl_req), .cl_wr(cl_wr), .cl_sector(cl_sector), .cl_block(cl_block), .cl_wdata(cl_wdata),
    .ct_req(ct_req), .ct_wr(ct_wr), .ct_sector(ct_sector), .ct_block(ct_block), .ct_wdata(ct_wdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rights(cfg_rights),
    .cl_take(cl_take), .ct_take(ct_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .viol(viol), .viol_side(viol_side)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int blk, input int k, input int seed);
    return 8'((blk * 37 + k * 11 + seed * 5 + 3) & 255);
  endfunction

  task automatic set_rights(input int blk, input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 6'(blk); cfg_rights = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_xfer(input bit side, input bit wr, input int blk, input int seed,
                         input bit exp_ok, input bit revoke);
    bit tk;
    @(negedge clk);
    if (side) begin
      ct_req = 1'b1; ct_wr = wr; ct_sector = 4'(blk / 4); ct_block = 2'(blk % 4);
    end else begin
      cl_req = 1'b1; cl_wr = wr; cl_sector = 4'(blk / 4); cl_block = 2'(blk % 4);
    end
    do begin
      @(negedge clk);
      tk = side ? ct_take : cl_take;
    end while (!tk);
    cl_req = 1'b0; ct_req = 1'b0;
    if (revoke) begin
      cfg_we = 1'b1; cfg_idx = 6'(blk); cfg_rights = 4'h0;
    end
    chk((side ? cl_take : ct_take) == 1'b0, "R8 only owner take", 1, 0);
    if (!exp_ok) begin
      chk(viol == 1'b1, "R4 viol on refusal", int'(viol), 1);
      chk(viol_side == side, "R4 viol_side", int'(viol_side), int'(side));
      chk(rd_data == 8'h00 && rd_valid == 1'b0, "R4 zero data on refusal", int'(rd_data), 0);
      @(negedge clk);
      chk(viol == 1'b0, "R4 viol one cycle", int'(viol), 0);
      chk(cl_take == 1'b0 && ct_take == 1'b0, "R8 take one cycle", int'(cl_take | ct_take), 0);
    end else begin
      chk(viol == 1'b0, "R3 granted no viol", int'(viol), 0);
      if (wr) begin
        for (int k = 0; k < 16; k++) begin
          if (side) begin
            ct_wdata = pat(blk, k, seed); cl_wdata = ~pat(blk, k, seed);
          end else begin
            cl_wdata = pat(blk, k, seed); ct_wdata = ~pat(blk, k, seed);
          end
          @(negedge clk);
          cfg_we = 1'b0;
          if (k == 3) chk(cl_take == 1'b0 && ct_take == 1'b0, "R8 busy no take", 1, 0);
          if (k == 14) chk(done == 1'b0, "R6 done not early", int'(done), 0);
        end
        chk(done == 1'b1, "R6 write done in cycle 16", int'(done), 1);
        for (int k = 0; k < 16; k++) model[blk * 16 + k] = pat(blk, k, seed);
      end else begin
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          cfg_we = 1'b0;
          chk(rd_valid == 1'b1, "R6 rd_valid on beat", int'(rd_valid), 1);
          chk(rd_data == model[blk * 16 + k], revoke ? "R7 data after revoke" : "R2 read data",
              int'(rd_data), int'(model[blk * 16 + k]));
          if (k >= 14) chk(done == (k == 15), "R6 done on last byte", int'(done), int'(k == 15));
        end
        @(negedge clk);
        chk(rd_valid == 1'b0 && rd_data == 8'h00, "R4 data zero after read", int'(rd_data), 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    cl_req = 0; cl_wr = 0; cl_sector = 0; cl_block = 0; cl_wdata = 0;
    ct_req = 0; ct_wr = 0; ct_sector = 0; ct_block = 0; ct_wdata = 0;
    cfg_we = 0; cfg_idx = 0; cfg_rights = 0;
    for (int a = 0; a < 1024; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({cl_take, ct_take, rd_valid, done, viol} == 5'b0 && rd_data == 8'h00,
        "R1 reset outputs", int'({cl_take, ct_take, rd_valid, done, viol}), 0);

    // R1: empty table refuses everything
    do_xfer(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    do_xfer(1'b0, 1'b1, 63, 0, 1'b0, 1'b0);
    do_xfer(1'b1, 1'b0, 17, 0, 1'b0, 1'b0);
    do_xfer(1'b1, 1'b1, 42, 0, 1'b0, 1'b0);

    // R9 + R2: open all blocks, write every block, read back from other side
    for (int b = 0; b < 64; b++) set_rights(b, 4'hF);
    for (int b = 0; b < 64; b++) do_xfer(b[0], 1'b1, b, 1, 1'b1, 1'b0);
    for (int b = 0; b < 64; b++) do_xfer(~b[0], 1'b0, b, 0, 1'b1, 1'b0);

    // R3/R4/R9: full rights sweep on one block
    for (int v = 0; v < 16; v++) begin
      set_rights(21, 4'(v));
      for (int s = 0; s < 2; s++) begin
        do_xfer(s[0], 1'b1, 21, 100 + v * 2 + s, v[s * 2 + 1], 1'b0);
        do_xfer(s[0], 1'b0, 21, 0, v[s * 2], 1'b0);
      end
    end
    set_rights(21, 4'hF);
    do_xfer(1'b0, 1'b0, 21, 0, 1'b1, 1'b0);

    // R5: simultaneous requests
    @(negedge clk);
    cl_req = 1; cl_wr = 0; cl_sector = 0; cl_block = 0;
    ct_req = 1; ct_wr = 0; ct_sector = 0; ct_block = 1;
    @(negedge clk);
    chk(cl_take == 1'b1 && ct_take == 1'b0, "R5 contactless wins", int'({cl_take, ct_take}), 2);
    cl_req = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n < 17) chk(ct_take == 1'b0, "R5 contact stalled", int'(ct_take), 0);
    end while (!ct_take && n < 40);
    chk(n == 17, "R5 contact take delay", n, 17);
    ct_req = 0;
    repeat (18) @(negedge clk);
    chk(done == 1'b0 && rd_valid == 1'b0, "R6 idle after stalled read", int'(done), 0);

    // R7: revoke during transfer, then check the next request sees it
    do_xfer(1'b0, 1'b0, 2, 0, 1'b1, 1'b1);
    do_xfer(1'b0, 1'b0, 2, 0, 1'b0, 1'b0);
    do_xfer(1'b1, 1'b1, 2, 7, 1'b0, 1'b0);
    set_rights(2, 4'b0100);
    do_xfer(1'b1, 1'b0, 2, 0, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule